// File: doc/BRIEF.md
# Synchronous Serial Clock Generator

This block drives the serial clock pin of a serial port that runs as clock master in synchronous mode. A bit-rate tick from an external divider marks every half bit period, and each bit period is one full clock cycle: a high half followed by a low half. The clock rests low whenever no cycle is in progress.

Two control bits choose when the clock runs. In gated (on-character) mode the clock cycles only while the transmitter is sending a character, or while the receiver still needs edges to complete a character it has started. In continuous mode the clock runs all the time, so the receiver can take data with no transmission going on. A self-clearing option is also available. With it set, the first complete received character clears the continuous bit and the option bit together, and the clock returns to gated mode. A phase state machine has three states: PH_IDLE (clock low, at rest), PH_HIGH (high half) and PH_LOW (low half). The transitions are START (PH_IDLE to PH_HIGH on a tick while the clock is wanted), FALL (PH_HIGH to PH_LOW on a tick), REPEAT (PH_LOW to PH_HIGH on a tick while the clock is wanted) and PARK (PH_LOW to PH_IDLE on a tick when it is not wanted).

Top module: `sync_sclk_gen`

## Requirements
- R1: After reset the clock output is 0 and both control outputs (continuous, self-clear) are 0.
- R2: With continuous mode off and neither transmit-active nor receive-busy asserted, the clock stays 0 whatever the tick does.
- R3: A rising clock edge happens only when the clock is wanted: continuous mode is on, transmit-active is high, or receive-busy is high.
- R4: While the clock is wanted, each tick toggles the clock, so one clock period spans two ticks and starts with the high half.
- R5: With continuous mode on, the clock cycles with transmit-active and receive-busy both low.
- R6: When the clock stops being wanted, the current cycle still completes. A high half ends only on a tick, the low half that follows also lasts until a tick, and then the clock rests at 0.
- R7: The clock output changes only on the clock edge where the tick is sampled high.
- R8: A control write loads the continuous and self-clear bits from the write inputs, and both are visible on the control outputs from the next cycle.
- R9: With self-clear set, a receive-complete pulse clears both the continuous bit and the self-clear bit in the next cycle.
- R10: With self-clear clear, a receive-complete pulse leaves both control bits unchanged. Without a write or a self-clear event, the control bits hold.
- R11: If a control write and a self-clear event fall in the same cycle, the self-clear wins and both bits end at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse marking each half bit period |
| tx_active | input | 1 | Transmitter is sending a character |
| rx_busy | input | 1 | Receiver is partway through a character |
| rx_char_done | input | 1 | One-cycle pulse when a full character has been received |
| ctl_wr | input | 1 | Control write strobe |
| ctl_cont_in | input | 1 | Continuous-mode value to write |
| ctl_aclr_in | input | 1 | Self-clear value to write |
| sclk | output | 1 | Serial clock output, rests low |
| cont_mode | output | 1 | Current continuous-mode bit |
| auto_clr | output | 1 | Current self-clear bit |

## Verification
The hardest case to reach from the ports is a control write in the same cycle as a self-clear event. The self-clear bit must already be set, and the write and the receive-complete pulse must then be driven together in one cycle. The bench first loads both control bits, then issues that combined cycle with a write that would keep continuous mode on, and checks that both bits read 0. A second hard case is demand dropping partway through a high half. The bench lets a receive start the clock, then drops receive-busy with no tick pending and watches the high level hold for several cycles before the two closing ticks.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    typedef struct packed {
        logic cont;
        logic aclr;
    } ctl_bits_t;

endpackage

// File: rtl/sclk_ctl_reg.sv
module sclk_ctl_reg
    import sclk_gen_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  ctl_bits_t wr_val,
    input  logic      rx_char_done,
    output ctl_bits_t ctl_q
);

    logic      self_clear_evt;
    ctl_bits_t ctl_nxt;

    assign self_clear_evt = ctl_q.aclr && rx_char_done;

    always_comb begin
        ctl_nxt = ctl_q;
        if (self_clear_evt) begin
            // self-clear takes priority over a concurrent write
            ctl_nxt = '0;
        end else if (wr_en) begin
            ctl_nxt = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_nxt;
    end

endmodule

// File: rtl/sclk_phase_fsm.sv
module sclk_phase_fsm
    import sclk_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic want_clk,
    output logic sclk_q
);

    phase_e state_q, state_nxt;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            PH_IDLE: if (tick && want_clk) state_nxt = PH_HIGH;   // START
            PH_HIGH: if (tick)             state_nxt = PH_LOW;    // FALL
            PH_LOW:  if (tick)             state_nxt = want_clk ? PH_HIGH  // REPEAT
                                                                : PH_IDLE; // PARK
            default:                       state_nxt = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_nxt;
    end

    // registered output, glitch-free pin drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= (state_nxt == PH_HIGH);
    end

endmodule

// File: rtl/sync_sclk_gen.sv
module sync_sclk_gen
    import sclk_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic tx_active,
    input  logic rx_busy,
    input  logic rx_char_done,
    input  logic ctl_wr,
    input  logic ctl_cont_in,
    input  logic ctl_aclr_in,
    output logic sclk,
    output logic cont_mode,
    output logic auto_clr
);

    ctl_bits_t ctl_wval;
    ctl_bits_t ctl_cur;
    logic      want_clk;

    assign ctl_wval.cont = ctl_cont_in;
    assign ctl_wval.aclr = ctl_aclr_in;

    sclk_ctl_reg u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (ctl_wr),
        .wr_val       (ctl_wval),
        .rx_char_done (rx_char_done),
        .ctl_q        (ctl_cur)
    );

    assign want_clk = ctl_cur.cont | tx_active | rx_busy;

    sclk_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_tick),
        .want_clk (want_clk),
        .sclk_q   (sclk)
    );

    assign cont_mode = ctl_cur.cont;
    assign auto_clr  = ctl_cur.aclr;

endmodule

// File: rtl/sync_sclk_gen_chk.sv
module sync_sclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic tx_active,
    input logic rx_busy,
    input logic rx_char_done,
    input logic ctl_wr,
    input logic ctl_cont_in,
    input logic ctl_aclr_in,
    input logic sclk,
    input logic cont_mode,
    input logic auto_clr
);

    assert_edge_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> $past(bit_tick));

    assert_rise_wanted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $past(cont_mode || tx_active || rx_busy));

    assert_high_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && !bit_tick) |=> sclk);

    assert_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_clr && rx_char_done) |=> (!cont_mode && !auto_clr));

    assert_write_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !(auto_clr && rx_char_done)) |=>
            (cont_mode == $past(ctl_cont_in) && auto_clr == $past(ctl_aclr_in)));

    assert_ctl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && !(auto_clr && rx_char_done)) |=> ($stable(cont_mode) && $stable(auto_clr)));

endmodule

bind sync_sclk_gen sync_sclk_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .tx_active    (tx_active),
    .rx_busy      (rx_busy),
    .rx_char_done (rx_char_done),
    .ctl_wr       (ctl_wr),
    .ctl_cont_in  (ctl_cont_in),
    .ctl_aclr_in  (ctl_aclr_in),
    .sclk         (sclk),
    .cont_mode    (cont_mode),
    .auto_clr     (auto_clr)
);

// File: tb/sync_sclk_gen_tb.sv
module sync_sclk_gen_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0, tx_active = 1'b0, rx_busy = 1'b0, rx_char_done = 1'b0;
    logic ctl_wr = 1'b0, ctl_cont_in = 1'b0, ctl_aclr_in = 1'b0;
    logic sclk, cont_mode, auto_clr;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    sync_sclk_gen u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_active(tx_active),
        .rx_busy(rx_busy), .rx_char_done(rx_char_done), .ctl_wr(ctl_wr),
        .ctl_cont_in(ctl_cont_in), .ctl_aclr_in(ctl_aclr_in),
        .sclk(sclk), .cont_mode(cont_mode), .auto_clr(auto_clr)
    );

    // gated-mode vectors: {tick, tx_active, rx_busy, expected sclk}
    localparam int NV = 14;
    localparam logic [3:0] VEC [NV] = '{
        4'b1000,  // R2 tick, nothing wanted
        4'b0100,  // R7 wanted, no tick
        4'b1101,  // R4 START
        4'b0101,  // R7 hold high
        4'b1100,  // R4 FALL
        4'b1101,  // R4 REPEAT
        4'b1000,  // R6 FALL, demand gone
        4'b1000,  // R6 PARK
        4'b1011,  // R4 rx_busy starts clock
        4'b0001,  // R6 demand gone, high half held
        4'b0001,  // R6 still held
        4'b1000,  // R6 low half
        4'b1000,  // R6 PARK
        4'b1000   // R2 rest
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic step(input logic tk, input logic tx, input logic rx,
                        input logic dn, input logic wr, input logic wc, input logic wa);
        @(negedge clk);
        bit_tick = tk; tx_active = tx; rx_busy = rx; rx_char_done = dn;
        ctl_wr = wr; ctl_cont_in = wc; ctl_aclr_in = wa;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #20;
        check("R1 sclk", sclk, 1'b0);
        check("R1 cont", cont_mode, 1'b0);
        check("R1 aclr", auto_clr, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][3], VEC[i][2], VEC[i][1], 1'b0, 1'b0, 1'b0, 1'b0);
            check("R2/R4/R6/R7 vector", sclk, VEC[i][0]);
        end

        // R8 load continuous mode only
        step(0, 0, 0, 0, 1, 1, 0);
        check("R8 cont", cont_mode, 1'b1);
        check("R8 aclr", auto_clr, 1'b0);
        // R5 free-running clock without tx/rx
        step(1, 0, 0, 0, 0, 0, 0); check("R5 high", sclk, 1'b1);
        step(1, 0, 0, 0, 0, 0, 0); check("R5 low", sclk, 1'b0);
        step(1, 0, 0, 0, 0, 0, 0); check("R5 high again", sclk, 1'b1);
        // R10 receive-complete without self-clear
        step(0, 0, 0, 1, 0, 0, 0);
        check("R10 cont kept", cont_mode, 1'b1);
        check("R10 sclk held", sclk, 1'b1);
        // R8 load both
        step(0, 0, 0, 0, 1, 1, 1);
        check("R8 aclr set", auto_clr, 1'b1);
        // R9 self-clear event
        step(0, 0, 0, 1, 0, 0, 0);
        check("R9 cont cleared", cont_mode, 1'b0);
        check("R9 aclr cleared", auto_clr, 1'b0);
        check("R6 high kept after clear", sclk, 1'b1);
        step(1, 0, 0, 0, 0, 0, 0); check("R6 low half", sclk, 1'b0);
        step(1, 0, 0, 0, 0, 0, 0); check("R6 parked", sclk, 1'b0);
        step(1, 0, 0, 0, 0, 0, 0); check("R2 gated rest", sclk, 1'b0);
        // R11 write colliding with self-clear
        step(0, 0, 0, 0, 1, 1, 1);
        check("R8 reload aclr", auto_clr, 1'b1);
        step(0, 0, 0, 1, 1, 1, 0);
        check("R11 cont", cont_mode, 1'b0);
        check("R11 aclr", auto_clr, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule